// File: doc/BRIEF.md
# Addressable Latch with Demultiplexer Mode

This block is an eight-output addressable storage element whose outputs stand in for open-drain drivers. A logic 1 on an output means the driver is off, and a logic 0 means the driver pulls low. A binary select picks one output. A single data bit is written to that output in inverted form, so writing a 1 turns the selected driver on.

Two active-low controls choose one of four modes: an enable (`en_n`) and a clear (`clr_n`). In latch mode, one addressed bit is written and the other bits keep their values. In hold mode, every bit is frozen. In decode mode, the block acts as a one-of-eight demultiplexer: the addressed output shows the inverted data and every other output is off. In clear mode, every output is off.

All inputs are sampled on the rising edge of the system clock, and the outputs come straight from flops. Software or surrounding logic is expected to keep `en_n` high while it changes the select lines.

Top module: `addr_latch_demux`

## Requirements
- R1: While `rst` is high at a rising clock edge, all bits of `q_drv` are 1 after that edge.
- R2: Latch mode is `clr_n`=1 and `en_n`=0. After the edge, bit `sel` of `q_drv` equals the inverse of `data_in`, and every other bit keeps its value from before the edge.
- R3: Hold mode is `clr_n`=1 and `en_n`=1. `q_drv` does not change at the edge, whatever `data_in` and `sel` are.
- R4: Decode mode is `clr_n`=0 and `en_n`=0. After the edge, bit `sel` equals the inverse of `data_in` and every other bit is 1.
- R5: Clear mode is `clr_n`=0 and `en_n`=1. After the edge, all bits of `q_drv` are 1, whatever `data_in` and `sel` are.
- R6: `sel` is plain binary with bit 2 as the most significant bit. A value k in 0..7 addresses bit k of `q_drv`.
- R7: When decode mode is followed by hold mode, the pattern last driven in decode mode stays on `q_drv`. The stored state follows the decoded outputs.
- R8: Outputs are registered. Inputs present at one rising edge show on `q_drv` right after that edge, and a single cycle of `en_n` low is enough to complete a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset; sets all outputs off (1) |
| data_in | input | 1 | Data bit; its inverse is written to the addressed output |
| sel | input | 3 | Binary output address |
| en_n | input | 1 | Active-low enable |
| clr_n | input | 1 | Active-low clear |
| q_drv | output | 8 | Driver states; 1 means the driver is off |

## Verification
The hardest case to reach from the ports is the hand-over from decode mode into hold mode. In that case the stored state has to equal the forced one-of-eight pattern and not whatever the latch held before. The stimulus reaches it in three steps. First it loads a latch pattern that differs from the decoded one. Then it runs a single decode cycle at a different address. Finally it raises the enable and sweeps every address and data value in hold mode, checking that the decoded pattern survives unchanged.

// File: rtl/alatch_pkg.sv
package alatch_pkg;
  // Encoding follows {clr_n, en_n}
  typedef enum logic [1:0] {
    MODE_DECODE = 2'b00,
    MODE_CLEAR  = 2'b01,
    MODE_LATCH  = 2'b10,
    MODE_HOLD   = 2'b11
  } alatch_mode_e;
endpackage

// File: rtl/alatch_mode_dec.sv
module alatch_mode_dec
  import alatch_pkg::*;
(
  input  logic         clr_n,
  input  logic         en_n,
  output alatch_mode_e mode
);
  always_comb begin
    case ({clr_n, en_n})
      2'b00:   mode = MODE_DECODE;
      2'b01:   mode = MODE_CLEAR;
      2'b10:   mode = MODE_LATCH;
      default: mode = MODE_HOLD;
    endcase
  end
endmodule

// File: rtl/alatch_sel_dec.sv
module alatch_sel_dec #(
  parameter int OUT_W = 8,
  localparam int SEL_W = $clog2(OUT_W)
) (
  input  logic [SEL_W-1:0] sel,
  output logic [OUT_W-1:0] hot
);
  for (genvar k = 0; k < OUT_W; k++) begin : g_hot
    assign hot[k] = (sel == SEL_W'(k));
  end

  // R6: an in-range address always selects exactly one output
  always_comb begin
    if (int'(sel) < OUT_W)
      a_onehot_r6: assert ($countones(hot) == 1);
  end
endmodule

// File: rtl/alatch_state.sv
module alatch_state
  import alatch_pkg::*;
#(
  parameter int OUT_W = 8,
  localparam int SEL_W = $clog2(OUT_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  alatch_mode_e     mode,
  input  logic             data_in,
  input  logic [SEL_W-1:0] sel,
  input  logic [OUT_W-1:0] hot,
  output logic [OUT_W-1:0] q
);
  logic [OUT_W-1:0] q_nxt;

  for (genvar k = 0; k < OUT_W; k++) begin : g_bit
    always_comb begin
      case (mode)
        MODE_LATCH:  q_nxt[k] = hot[k] ? ~data_in : q[k];
        MODE_DECODE: q_nxt[k] = hot[k] ? ~data_in : 1'b1;
        MODE_CLEAR:  q_nxt[k] = 1'b1;
        default:     q_nxt[k] = q[k];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '1;
    else     q <= q_nxt;
  end

  p_reset_off_r1: assert property (@(posedge clk) rst |=> (q == '1));

  p_latch_bit_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_LATCH) |=> (q[$past(sel)] == ~$past(data_in)));

  p_latch_others_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_LATCH) |=> ((q & ~$past(hot)) == ($past(q) & ~$past(hot))));

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HOLD) |=> $stable(q));

  p_decode_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DECODE) |=> (q[$past(sel)] == ~$past(data_in)));

  p_decode_rest_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DECODE) |=> $countones(q) >= OUT_W - 1);

  p_clear_off_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CLEAR) |=> (q == '1));
endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
  import alatch_pkg::*;
#(
  parameter int OUT_W = 8,
  localparam int SEL_W = $clog2(OUT_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             data_in,
  input  logic [SEL_W-1:0] sel,
  input  logic             en_n,
  input  logic             clr_n,
  output logic [OUT_W-1:0] q_drv
);
  alatch_mode_e     mode;
  logic [OUT_W-1:0] hot;

  alatch_mode_dec u_mode (
    .clr_n (clr_n),
    .en_n  (en_n),
    .mode  (mode)
  );

  alatch_sel_dec #(.OUT_W(OUT_W)) u_sel (
    .sel (sel),
    .hot (hot)
  );

  alatch_state #(.OUT_W(OUT_W)) u_state (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .data_in (data_in),
    .sel     (sel),
    .hot     (hot),
    .q       (q_drv)
  );

  // R7: a decode cycle followed by a hold cycle keeps the decoded pattern
  p_decode_then_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HOLD && $past(mode) == MODE_DECODE && !$past(rst)) |=> $stable(q_drv));
endmodule

// File: tb/addr_latch_demux_tb.sv
module addr_latch_demux_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       data_in;
  logic [2:0] sel;
  logic       en_n;
  logic       clr_n;
  logic [7:0] q_drv;
  logic [7:0] exp_q;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  addr_latch_demux u_dut (
    .clk(clk), .rst(rst), .data_in(data_in), .sel(sel),
    .en_n(en_n), .clr_n(clr_n), .q_drv(q_drv)
  );

  task automatic summary_and_end();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      summary_and_end();
    end
  end

  task automatic check(string req, logic [7:0] exp);
    checks++;
    if (q_drv !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, q_drv, exp);
    end
  endtask

  // Drive at the falling edge; the result is sampled just after the next rising edge
  task automatic step(logic d, logic [2:0] s, logic en, logic clr);
    @(negedge clk);
    data_in = d; sel = s; en_n = en; clr_n = clr;
    @(posedge clk);
    #1;
  endtask

  task automatic test_reset();
    rst = 1'b1;
    step(1'b1, 3'd0, 1'b0, 1'b0);
    check("R1 reset", 8'hFF);
    rst = 1'b0;
  endtask

  task automatic test_latch();
    exp_q = 8'hFF;
    for (int a = 0; a < 8; a++) begin
      logic d;
      d = a[0];
      step(d, 3'(a), 1'b0, 1'b1);
      exp_q[a] = ~d;
      check("R2 R6 R8 latch write", exp_q);
    end
    for (int a = 7; a >= 0; a--) begin
      step(1'b1, 3'(a), 1'b0, 1'b1);
      exp_q[a] = 1'b0;
      check("R2 latch data 1", exp_q);
      step(1'b0, 3'(a), 1'b0, 1'b1);
      exp_q[a] = 1'b1;
      check("R2 latch data 0", exp_q);
      step(1'b1, 3'(a), 1'b0, 1'b1);
      exp_q[a] = 1'b0;
    end
  endtask

  task automatic test_hold();
    for (int a = 0; a < 8; a++) begin
      for (int d = 0; d < 2; d++) begin
        step(d[0], 3'(a), 1'b1, 1'b1);
        check("R3 hold ignores address and data", exp_q);
      end
    end
  endtask

  task automatic test_decode();
    for (int a = 0; a < 8; a++) begin
      for (int d = 0; d < 2; d++) begin
        step(d[0], 3'(a), 1'b0, 1'b0);
        exp_q = 8'hFF;
        exp_q[a] = ~d[0];
        check("R4 R6 decode", exp_q);
      end
    end
  endtask

  task automatic test_decode_to_hold();
    step(1'b1, 3'd0, 1'b0, 1'b1);
    step(1'b1, 3'd1, 1'b0, 1'b1);
    step(1'b1, 3'd6, 1'b0, 1'b0);
    exp_q = 8'b1011_1111;
    check("R7 decode before hold", exp_q);
    for (int a = 0; a < 8; a++) begin
      step(~a[0], 3'(a), 1'b1, 1'b1);
      check("R7 decoded pattern kept in hold", exp_q);
    end
    step(1'b1, 3'd2, 1'b0, 1'b1);
    exp_q[2] = 1'b0;
    check("R7 R2 latch on top of decoded state", exp_q);
  endtask

  task automatic test_clear();
    for (int a = 0; a < 8; a += 3) begin
      step(1'b1, 3'(a), 1'b0, 1'b1);
      step(1'b1, 3'(a), 1'b1, 1'b0);
      check("R5 clear", 8'hFF);
    end
  endtask

  initial begin
    rst = 1'b1; data_in = 1'b0; sel = '0; en_n = 1'b1; clr_n = 1'b1;
    test_reset();
    test_latch();
    test_hold();
    test_decode();
    test_decode_to_hold();
    test_clear();
    summary_and_end();
  end
endmodule